// File: doc/BRIEF.md
# Quad-Channel DAC Two-Wire Command Port

This block is the serial command front end of a four-channel digital-to-analog converter. It sits on an I2C bus as a slave. It answers to a 7-bit address made of the fixed prefix `001` followed by four strap inputs, and it turns write traffic into updates of three kinds of register. Each channel has an input (CODE) register and an output (DAC) register, and a shared register holds one power-down flag per channel. A write frame carries any number of three-byte blocks: a command byte, a data high byte and a data low byte. Each block takes effect when the slave acknowledges its third byte.

The same port serves readback in the combined format. The master writes the address, writes one command byte naming what to read, issues a repeated START, sends the address with the read bit set, and then clocks two data bytes out of the slave. What comes back depends on the command nibble. It can be a CODE register, a DAC register, or the power flags packed into the low nibble. If the master keeps reading after the two data bytes, every further byte is all ones.

The bus is modelled with separate input and drive-enable signals. The slave only ever pulls SDA low. Both lines pass through a synchronizer clocked by the system clock, and all protocol decisions are made on edges detected in that clock domain. The link state machine has the states `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_RX`, `ST_RX_ACK`, `ST_TX`, `ST_TX_ACK` and `ST_IGNORE`. Its transitions are as follows:
- START from any state goes to `ST_ADDR`, and STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` on a mismatch, at the SCL fall after the eighth bit.
- `ST_ADDR_ACK` goes to `ST_RX` (write) or `ST_TX` (read) at the fall that ends the acknowledge clock.
- `ST_RX` and `ST_RX_ACK` alternate for every received byte.
- `ST_TX` and `ST_TX_ACK` alternate for every sent byte while the master acknowledges.
- `ST_TX_ACK` goes to `ST_IGNORE` when the master does not acknowledge.

Top module: `quad_dac_i2c_port`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `001` followed by `addr_sel[3:0]`. For any other address it keeps SDA released for the address acknowledge and for every later byte until the next START, and no register changes.
- R2: In a write frame the slave acknowledges every command, high and low byte. Each block executes when its third byte is acknowledged, and several blocks may follow each other within one frame.
- R3: Command nibble 0000 (bits 23:20) writes data bits 15:4 into the CODE register of the channel named by bits 19:16. Values 0..3 select channels A..D and values 4..15 select all channels.
- R4: Command nibbles 0001, 0010 and 0011 copy the CODE register into the DAC register of the selected channel or channels, using the same channel field as R3. CODE registers are unchanged.
- R5: Command nibble 0100 loads the power flags from data bits 3:0, where bit i belongs to channel i and 1 means powered down. The channel field is ignored.
- R6: A frame that ends with a STOP before the third byte of a block leaves all registers unchanged.
- R7: A readback selected by command nibble 0000 returns the CODE register of the named channel left-justified in 16 bits, high byte first. With an all-channels value it returns channel A.
- R8: A readback selected by nibbles 0001..0011 returns the DAC register of the named channel in the same format. With an all-channels value it returns channel A.
- R9: A readback selected by nibble 0100 returns the power flags in bits 3:0 and zeros in bits 15:4.
- R10: Read bytes clocked after the two data bytes are 0xFF.
- R11: The SDA drive enable changes only while the synchronized SCL is low.
- R12: After reset all CODE, DAC and power flags are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 4 | Low four bits of the slave address |
| code_flat | output | NCH*DW (48) | CODE registers, channel c at bits c*DW +: DW |
| dac_flat | output | NCH*DW (48) | DAC registers, same packing |
| pwr_down | output | NCH (4) | Power-down flag per channel, 1 = powered down |

## Verification
The bench builds the block with its defaults: four channels, 12-bit codes, a two-stage line synchronizer and the address prefix `001`, with `addr_sel` strapped to 0101. Four channels make the channel field reach both the per-channel values 0..3 and the all-channels values above 3, so the channel-A fallback on readback can be observed. A 12-bit code leaves a 4-bit zero tail in each readback word, so left justification is visible in the low byte. The scoreboard covers chained blocks, a foreign address, a frame cut after two bytes, and reads that run past the two data bytes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_t;

    localparam logic [3:0] OP_CODE  = 4'h0;
    localparam logic [3:0] OP_LOAD1 = 4'h1;
    localparam logic [3:0] OP_LOAD2 = 4'h2;
    localparam logic [3:0] OP_LOAD3 = 4'h3;
    localparam logic [3:0] OP_POWER = 4'h4;

    function automatic logic op_is_load(input logic [3:0] op);
        return (op == OP_LOAD1) || (op == OP_LOAD2) || (op == OP_LOAD3);
    endfunction

endpackage

// File: rtl/qdac_line_sync.sv
module qdac_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/qdac_link_fsm.sv
module qdac_link_fsm
    import qdac_pkg::*;
#(
    parameter logic [2:0] ADDR_HI = 3'b001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_s,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic [3:0]  addr_sel,
    input  logic [15:0] rd_word,
    output logic        sda_oe,
    output logic        exec,
    output logic [7:0]  blk_cmd,
    output logic [15:0] blk_data,
    output logic [7:0]  rd_cmd
);
    link_state_t state, nxt;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic [1:0]  byte_idx;
    logic [1:0]  tx_idx;
    logic        mack;
    logic [7:0]  cmd_q, hi_q, lo_q;
    logic [7:0]  tx_next;
    logic        addr_hit;
    logic        byte_done;

    assign addr_hit  = (shreg[7:1] == {ADDR_HI, addr_sel});
    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign blk_cmd   = cmd_q;
    assign blk_data  = {hi_q, lo_q};

    always_comb begin
        case (tx_idx)
            2'd0:    tx_next = rd_word[15:8];
            2'd1:    tx_next = rd_word[7:0];
            default: tx_next = 8'hFF;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? ST_TX : ST_RX;
                ST_RX:       if (byte_done) nxt = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) nxt = ST_RX;
                ST_TX:       if (byte_done) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = mack ? ST_IGNORE : ST_TX;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            byte_idx <= '0;
            tx_idx   <= '0;
            mack     <= 1'b1;
            cmd_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            rd_cmd   <= '0;
            sda_oe   <= 1'b0;
            exec     <= 1'b0;
        end else begin
            exec <= 1'b0;
            if (start_det) begin
                bitcnt   <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            sda_oe <= addr_hit;
                            tx_idx <= '0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (shreg[0]) begin
                                shreg  <= rd_word[15:8];
                                sda_oe <= ~rd_word[15];
                                tx_idx <= 2'd1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b1;
                            case (byte_idx)
                                2'd0: begin
                                    cmd_q  <= shreg;
                                    rd_cmd <= shreg;
                                end
                                2'd1:    hi_q <= shreg;
                                default: lo_q <= shreg;
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (byte_idx == 2'd2) begin
                                exec     <= 1'b1;
                                byte_idx <= '0;
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b1};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= sda_s;
                        end else if (scl_fall && !mack) begin
                            shreg  <= tx_next;
                            sda_oe <= ~tx_next[7];
                            if (tx_idx != 2'd2) tx_idx <= tx_idx + 2'd1;
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R11: the pad drive only moves while the bus clock is low
    assert_sda_change_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R1: a foreign address never sees the slave pull SDA
    assert_ignore_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R2: a block executes for exactly one system clock
    assert_exec_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [7:0]        blk_cmd,
    input  logic [15:0]       blk_data,
    input  logic [7:0]        rd_cmd,
    output logic [NCH*DW-1:0] code_flat,
    output logic [NCH*DW-1:0] dac_flat,
    output logic [NCH-1:0]    pwr_down,
    output logic [15:0]       rd_word
);
    localparam int PAD = 16 - DW;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [DW-1:0]  code_q [NCH];
    logic [DW-1:0]  dac_q  [NCH];
    logic [NCH-1:0] pd_q;
    logic [NCH-1:0] wr_sel;
    logic [CHW-1:0] rch;
    logic [3:0]     wr_op;

    assign wr_op = blk_cmd[7:4];

    always_comb begin
        if (int'(blk_cmd[3:0]) >= NCH) wr_sel = '1;
        else wr_sel = {{(NCH-1){1'b0}}, 1'b1} << blk_cmd[3:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[c] <= '0;
                dac_q[c]  <= '0;
            end else if (exec && wr_sel[c]) begin
                if (wr_op == OP_CODE)       code_q[c] <= blk_data[15 -: DW];
                else if (op_is_load(wr_op)) dac_q[c]  <= code_q[c];
            end
        end
        assign code_flat[c*DW +: DW] = code_q[c];
        assign dac_flat[c*DW +: DW]  = dac_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             pd_q <= '0;
        else if (exec && wr_op == OP_POWER)     pd_q <= blk_data[NCH-1:0];
    end
    assign pwr_down = pd_q;

    assign rch = (int'(rd_cmd[3:0]) >= NCH) ? '0 : rd_cmd[CHW-1:0];

    always_comb begin
        rd_word = '0;
        if (rd_cmd[7:4] == OP_CODE)           rd_word = 16'(code_q[rch]) << PAD;
        else if (op_is_load(rd_cmd[7:4]))     rd_word = 16'(dac_q[rch]) << PAD;
        else if (rd_cmd[7:4] == OP_POWER)     rd_word = 16'(pd_q);
    end

    // R3 and R6: CODE contents move only when a complete CODE block executes
    assert_code_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_flat) |-> $past(exec && blk_cmd[7:4] == OP_CODE));

    // R4: DAC contents move only when a complete load block executes
    assert_dac_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_flat) |-> $past(exec && op_is_load(blk_cmd[7:4])));

    // R5: power flags move only when a complete power block executes
    assert_pwr_only_on_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_down) |-> $past(exec && blk_cmd[7:4] == OP_POWER));

endmodule

// File: rtl/quad_dac_i2c_port.sv
module quad_dac_i2c_port #(
    parameter int         NCH         = 4,
    parameter int         DW          = 12,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] ADDR_HI     = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [3:0]        addr_sel,
    output logic [NCH*DW-1:0] code_flat,
    output logic [NCH*DW-1:0] dac_flat,
    output logic [NCH-1:0]    pwr_down
);
    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic        exec;
    logic [7:0]  blk_cmd, rd_cmd;
    logic [15:0] blk_data, rd_word;

    qdac_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    qdac_link_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .rd_word   (rd_word),
        .sda_oe    (sda_oe),
        .exec      (exec),
        .blk_cmd   (blk_cmd),
        .blk_data  (blk_data),
        .rd_cmd    (rd_cmd)
    );

    qdac_regbank #(.NCH(NCH), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec      (exec),
        .blk_cmd   (blk_cmd),
        .blk_data  (blk_data),
        .rd_cmd    (rd_cmd),
        .code_flat (code_flat),
        .dac_flat  (dac_flat),
        .pwr_down  (pwr_down),
        .rd_word   (rd_word)
    );

endmodule

// File: tb/quad_dac_i2c_port_tb.sv
module quad_dac_i2c_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] WADDR = 8'h2A;   // 001_0101, write
    localparam logic [7:0] RADDR = 8'h2B;   // 001_0101, read
    localparam logic [7:0] XADDR = 8'h2C;   // 001_0110, foreign

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic [3:0]  addr_sel = 4'b0101;
    logic [47:0] code_flat, dac_flat;
    logic [3:0]  pwr_down;
    wire         sda_line = ~(sda_oe | m_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dac_i2c_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .code_flat (code_flat),
        .dac_flat  (dac_flat),
        .pwr_down  (pwr_down)
    );

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];
    int   obs_val;
    event obs_ev;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // reference model of the register set
    logic [11:0] m_code [4];
    logic [11:0] m_dac  [4];
    logic [3:0]  m_pd;

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected observation actual=%0h expected=none", obs_val);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (obs_val !== it.val) begin
                    fails++;
                    $display("FAIL %s actual=%0h expected=%0h", it.req, obs_val, it.val);
                end
            end
        end
    end

    task automatic expect_item(input string req, input int val);
        exp_t it;
        it.req = req;
        it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic publish(input int val);
        obs_val = val;
        ->obs_ev;
        #1;
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b1; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qwait();
            scl = 1'b1;    qwait(); qwait();
            scl = 1'b0;    qwait();
        end
        m_low = 1'b0; qwait();
        scl = 1'b1;   qwait();
        ack = ~sda_line;
        qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl = 1'b1; qwait();
            b[i] = sda_line;
            qwait();
            scl = 1'b0; qwait();
        end
        m_low = give_ack; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
        m_low = 1'b0;
    endtask

    // model update follows R3, R4, R5 independently of the design
    task automatic model_block(input logic [7:0] cmd, input logic [7:0] hi, input logic [7:0] lo);
        for (int c = 0; c < 4; c++) begin
            if (cmd[3:0] >= 4 || int'(cmd[3:0]) == c) begin
                if (cmd[7:4] == 4'h0) m_code[c] = {hi, lo[7:4]};
                else if (cmd[7:4] inside {4'h1, 4'h2, 4'h3}) m_dac[c] = m_code[c];
            end
        end
        if (cmd[7:4] == 4'h4) m_pd = lo[3:0];
    endtask

    task automatic send_checked(input logic [7:0] b, input logic exp_ack, input string req);
        logic ack;
        expect_item(req, int'(exp_ack));
        send_byte(b, ack);
        publish(int'(ack));
    endtask

    task automatic block(input logic [7:0] cmd, input logic [7:0] hi, input logic [7:0] lo);
        send_checked(cmd, 1'b1, "R2");
        send_checked(hi,  1'b1, "R2");
        send_checked(lo,  1'b1, "R2");
        model_block(cmd, hi, lo);
    endtask

    task automatic check_regs(input string req);
        for (int c = 0; c < 4; c++) begin
            expect_item(req, int'(m_code[c]));
            publish(int'(code_flat[c*12 +: 12]));
            expect_item(req, int'(m_dac[c]));
            publish(int'(dac_flat[c*12 +: 12]));
        end
        expect_item(req, int'(m_pd));
        publish(int'(pwr_down));
    endtask

    task automatic readback(input logic [7:0] cmd, input logic [15:0] exp_word,
                            input int extra, input string req);
        logic [7:0] b;
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        send_checked(cmd,   1'b1, "R2");
        bus_start();
        send_checked(RADDR, 1'b1, "R1");
        expect_item(req, int'(exp_word[15:8]));
        recv_byte(1'b1, b);
        publish(int'(b));
        expect_item(req, int'(exp_word[7:0]));
        recv_byte(extra > 0, b);
        publish(int'(b));
        for (int k = 0; k < extra; k++) begin
            expect_item("R10", 8'hFF);
            recv_byte(k < extra - 1, b);
            publish(int'(b));
        end
        bus_stop();
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_code[c] = '0;
            m_dac[c]  = '0;
        end
        m_pd = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        qwait();

        // R12: reset state
        check_regs("R12");
        expect_item("R12", 0);
        publish(int'(sda_oe));

        // R3: all-channel write, then two chained single-channel blocks (R2)
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        block(8'h0F, 8'h55, 8'h50);
        block(8'h01, 8'hAB, 8'hC0);
        block(8'h02, 8'h12, 8'h30);
        bus_stop();
        check_regs("R3");

        // R1: foreign address is not acknowledged and changes nothing
        bus_start();
        send_checked(XADDR, 1'b0, "R1");
        send_checked(8'h00, 1'b0, "R1");
        send_checked(8'hFF, 1'b0, "R1");
        send_checked(8'hF0, 1'b0, "R1");
        bus_stop();
        check_regs("R1");

        // R4: load one channel, then rewrite A and load all with a different load code
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        block(8'h11, 8'h00, 8'h00);
        bus_stop();
        check_regs("R4");
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        block(8'h00, 8'h0A, 8'h00);
        block(8'h2C, 8'hFF, 8'hFF);
        bus_stop();
        check_regs("R4");

        // R5: power flags from data bits 3:0, channel field ignored
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        block(8'h41, 8'h00, 8'h05);
        bus_stop();
        check_regs("R5");

        // R6: block cut short by STOP after two bytes
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        send_checked(8'h03, 1'b1, "R6");
        send_checked(8'h99, 1'b1, "R6");
        bus_stop();
        check_regs("R6");

        // R3 again after the aborted frame: channel D write
        bus_start();
        send_checked(WADDR, 1'b1, "R1");
        block(8'h03, 8'h77, 8'h70);
        bus_stop();
        check_regs("R3");

        // R7: CODE readback for one channel and for all (falls back to A)
        readback(8'h02, {m_code[2], 4'h0}, 2, "R7");
        readback(8'h0F, {m_code[0], 4'h0}, 0, "R7");
        readback(8'h03, {m_code[3], 4'h0}, 1, "R7");

        // R8: DAC readback for one channel and for all (falls back to A)
        readback(8'h11, {m_dac[1], 4'h0}, 0, "R8");
        readback(8'h3F, {m_dac[0], 4'h0}, 1, "R8");

        // R9: power readback
        readback(8'h40, {12'h000, m_pd}, 3, "R9");

        // readbacks changed nothing
        check_regs("R6");

        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule